// File: doc/BRIEF.md
# Reloadable Down-Counting Interval Timer

This block is a 16-bit down-counter that sits on a small synchronous byte bus of an 8-bit controller. Software writes a 16-bit start value as two bytes and then sets a run bit. Only the step of that bit from 0 to 1 copies the start value into the counter, and it also lets the counting ticks through. Ticks come from a free-running prescaler. A two-bit rate field sets the tick rate to the input clock divided by 1, 2, 4 or 8.

When the counter steps from 0x0001 to 0x0000 a sticky expiry flag is set. On the next tick the counter takes the start value again and keeps counting. If the interrupt enable is set, the flag drives the interrupt line. Software reads the running count as two bytes. Reading the high byte captures the low byte at that moment, so the two halves always belong to the same count.

Top module: `reload_timer`

## Requirements
- R1: After reset the run bit, the interrupt enable, the rate field, the expiry flag, the start value and the count are all zero, and `irq` is low. Unused control bits read as 0.
- R2: The start value is written at address 1 (bits 15:8) and address 2 (bits 7:0). Both bytes read back at the same addresses.
- R3: The control register is at address 0. A write that changes the run bit (bit 0) from 0 to 1 loads the start value into the counter at that clock edge. A write of 1 while the bit is already 1 does not reload the counter.
- R4: While the run bit is 0 the count holds its value. Clearing the run bit freezes the count where it is.
- R5: The rate field (bits 3:2) codes 0, 1, 2 and 3 make the count move once every 1, 2, 4 and 8 clocks. The ticks come from a prescaler that runs freely from reset.
- R6: A tick that takes the count from 0x0001 to 0x0000 sets the expiry flag (bit 7). The tick after that reloads the start value. A start value written while the timer runs is used at the next reload.
- R7: `irq` is high exactly when the expiry flag and the interrupt enable (bit 1) are both set.
- R8: Writing 0 to the flag bit clears it, and writing 1 leaves it unchanged. If a clearing write and an expiry fall in the same cycle, the flag ends up set.
- R9: Address 3 reads count bits 15:8 and address 4 reads count bits 7:0. A read of address 3 copies the low byte into a hold register. Further reads of address 3 do not refresh the copy. A read of address 4 returns the held copy and releases it. With no copy pending, address 4 returns the live low byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 3 | Register address |
| wrData | input | 8 | Write data |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| rdData | output | 8 | Read data, valid in the cycle of `rdEn`, zero otherwise |
| irq | output | 1 | Interrupt request |

## Verification
The expiry flag can be set by the counter and cleared by a bus write at the same clock edge. The bench waits until its model shows the count at 0x0001 with a divide-by-one rate. It then issues a control write with the flag bit at 0, timed so that this write lands on the expiring tick. The flag must read back set afterwards, and the model, which applies the clear before the set, must agree with the design on `rdData` and `irq` in every cycle.

// File: rtl/reload_timer_pkg.sv
package reload_timer_pkg;

  // register addresses
  localparam int ADR_CTRL   = 0;
  localparam int ADR_PRE_HI = 1;
  localparam int ADR_PRE_LO = 2;
  localparam int ADR_CNT_HI = 3;
  localparam int ADR_CNT_LO = 4;

  // control register bit positions
  localparam int CTL_RUN    = 0;
  localparam int CTL_IRQEN  = 1;
  localparam int CTL_SEL_LO = 2;
  localparam int CTL_FLAG   = 7;

  // strobes from control to datapath
  typedef struct packed {
    logic load;        // rising run bit: take start value
    logic tick;        // prescaled count enable (already gated by run)
    logic snapHigh;    // high byte of count read
    logic releaseLow;  // low byte of count read
  } tmrStrobe_t;

endpackage

// File: rtl/reload_timer_ctrl.sv
module reload_timer_ctrl
  import reload_timer_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3,
  parameter int SEL_W  = 2,
  localparam int CNT_W = 2 * DATA_W,
  localparam int PRE_W = (1 << SEL_W) - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [CNT_W-1:0]  count,
  input  logic [DATA_W-1:0] lowView,
  input  logic              uflow,
  output logic [DATA_W-1:0] rdData,
  output logic              irq,
  output logic [CNT_W-1:0]  preset,
  output tmrStrobe_t        stb,
  output logic              runQ,
  output logic              flagQ
);

  logic             irqEnQ;
  logic [SEL_W-1:0] selQ;
  logic [PRE_W-1:0] preQ;
  logic [PRE_W-1:0] rateMask;
  logic             ctlWr;

  assign ctlWr = wrEn && (addr == ADDR_W'(ADR_CTRL));

  always_ff @(posedge clk) begin
    if (rst) begin
      runQ   <= 1'b0;
      irqEnQ <= 1'b0;
      selQ   <= '0;
      flagQ  <= 1'b0;
      preset <= '0;
      preQ   <= '0;
    end else begin
      preQ <= preQ + PRE_W'(1);
      if (ctlWr) begin
        runQ   <= wrData[CTL_RUN];
        irqEnQ <= wrData[CTL_IRQEN];
        selQ   <= wrData[CTL_SEL_LO +: SEL_W];
      end
      if (wrEn && (addr == ADDR_W'(ADR_PRE_HI))) preset[CNT_W-1:DATA_W] <= wrData;
      if (wrEn && (addr == ADDR_W'(ADR_PRE_LO))) preset[DATA_W-1:0]     <= wrData;
      // an expiry in the same cycle beats a clearing write
      if (uflow)                               flagQ <= 1'b1;
      else if (ctlWr && !wrData[CTL_FLAG])     flagQ <= 1'b0;
    end
  end

  always_comb begin
    rateMask       = PRE_W'((1 << selQ) - 1);
    stb.load       = ctlWr && wrData[CTL_RUN] && !runQ;
    stb.tick       = runQ && ((preQ & rateMask) == rateMask);
    stb.snapHigh   = rdEn && (addr == ADDR_W'(ADR_CNT_HI));
    stb.releaseLow = rdEn && (addr == ADDR_W'(ADR_CNT_LO));
  end

  always_comb begin
    rdData = '0;
    if (rdEn) begin
      if (addr == ADDR_W'(ADR_CTRL)) begin
        rdData[CTL_RUN]                = runQ;
        rdData[CTL_IRQEN]              = irqEnQ;
        rdData[CTL_SEL_LO +: SEL_W]    = selQ;
        rdData[CTL_FLAG]               = flagQ;
      end else if (addr == ADDR_W'(ADR_PRE_HI)) begin
        rdData = preset[CNT_W-1:DATA_W];
      end else if (addr == ADDR_W'(ADR_PRE_LO)) begin
        rdData = preset[DATA_W-1:0];
      end else if (addr == ADDR_W'(ADR_CNT_HI)) begin
        rdData = count[CNT_W-1:DATA_W];
      end else if (addr == ADDR_W'(ADR_CNT_LO)) begin
        rdData = lowView;
      end
    end
  end

  assign irq = flagQ && irqEnQ;

endmodule

// File: rtl/reload_timer_dp.sv
module reload_timer_dp
  import reload_timer_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  tmrStrobe_t        stb,
  input  logic [CNT_W-1:0]  preset,
  output logic [CNT_W-1:0]  count,
  output logic [DATA_W-1:0] lowView,
  output logic              uflow
);

  logic [DATA_W-1:0] holdQ;
  logic              frozenQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (stb.load) begin
      count <= preset;
    end else if (stb.tick) begin
      count <= (count == '0) ? preset : count - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      holdQ   <= '0;
      frozenQ <= 1'b0;
    end else begin
      if (stb.snapHigh && !frozenQ) begin
        holdQ   <= count[DATA_W-1:0];
        frozenQ <= 1'b1;
      end
      if (stb.releaseLow) frozenQ <= 1'b0;
    end
  end

  assign lowView = frozenQ ? holdQ : count[DATA_W-1:0];
  assign uflow   = stb.tick && !stb.load && (count == CNT_W'(1));

endmodule

// File: rtl/reload_timer.sv
module reload_timer
  import reload_timer_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrEn,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);

  localparam int CNT_W = 2 * DATA_W;

  tmrStrobe_t        stb;
  logic [CNT_W-1:0]  count;
  logic [CNT_W-1:0]  preset;
  logic [DATA_W-1:0] lowView;
  logic              uflow;
  logic              runQ;
  logic              flagQ;

  reload_timer_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_ctrl (
    .clk(clk), .rst(rst), .addr(addr), .wrData(wrData), .wrEn(wrEn), .rdEn(rdEn),
    .count(count), .lowView(lowView), .uflow(uflow), .rdData(rdData), .irq(irq),
    .preset(preset), .stb(stb), .runQ(runQ), .flagQ(flagQ)
  );

  reload_timer_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .stb(stb), .preset(preset),
    .count(count), .lowView(lowView), .uflow(uflow)
  );

endmodule

// File: rtl/reload_timer_chk.sv
module reload_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             loadStb,
  input logic             tickStb,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] preset,
  input logic             uflow,
  input logic             runQ,
  input logic             flagQ
);

  assert_load_takes_preset_R3: assert property (@(posedge clk) disable iff (rst)
    loadStb |=> (count == $past(preset)));

  assert_stopped_count_holds_R4: assert property (@(posedge clk) disable iff (rst)
    (!runQ && !loadStb) |=> $stable(count));

  assert_expiry_lands_on_zero_R6: assert property (@(posedge clk) disable iff (rst)
    uflow |=> (count == '0));

  assert_zero_reloads_R6: assert property (@(posedge clk) disable iff (rst)
    (tickStb && !loadStb && count == '0) |=> (count == $past(preset)));

  assert_expiry_sets_flag_R8: assert property (@(posedge clk) disable iff (rst)
    uflow |=> flagQ);

endmodule

bind reload_timer reload_timer_chk #(.CNT_W(2 * DATA_W)) u_chk (
  .clk(clk), .rst(rst), .loadStb(stb.load), .tickStb(stb.tick),
  .count(count), .preset(preset), .uflow(uflow), .runQ(runQ), .flagQ(flagQ)
);

// File: tb/reload_timer_bench.sv
module reload_timer_bench;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] addr = '0;
  logic [7:0] wrData = '0;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [7:0] rdData;
  logic       irq;

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 0;
  string curTag = "R1";

  // behavioural model state
  bit         mRun, mIe, mFlag, mFrozen;
  bit [1:0]   mSel;
  bit [15:0]  mPre, mCnt;
  bit [7:0]   mHold;
  int         mDiv;

  reload_timer u_reload_timer (
    .clk(clk), .rst(rst), .addr(addr), .wrData(wrData), .wrEn(wrEn),
    .rdEn(rdEn), .rdData(rdData), .irq(irq)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    bit uf, tk;
    bit [15:0] oldCnt;
    if (rst) begin
      mRun = 0; mIe = 0; mFlag = 0; mFrozen = 0; mSel = 0;
      mPre = 0; mCnt = 0; mHold = 0; mDiv = 0;
    end else begin
      oldCnt = mCnt;
      tk = mRun && ((mDiv % (1 << mSel)) == (1 << mSel) - 1);
      uf = tk && (oldCnt == 16'd1);
      if (rdEn && addr == 3'd3 && !mFrozen) begin mHold = oldCnt[7:0]; mFrozen = 1; end
      if (rdEn && addr == 3'd4) mFrozen = 0;
      if (tk) mCnt = (oldCnt == 0) ? mPre : oldCnt - 16'd1;
      if (wrEn && addr == 3'd0 && wrData[0] && !mRun) mCnt = mPre;
      if (wrEn && addr == 3'd0) begin
        mRun = wrData[0]; mIe = wrData[1]; mSel = wrData[3:2];
        if (!wrData[7]) mFlag = 0;
      end
      if (wrEn && addr == 3'd1) mPre[15:8] = wrData;
      if (wrEn && addr == 3'd2) mPre[7:0]  = wrData;
      if (uf) mFlag = 1;
      mDiv = (mDiv + 1) % 8;
    end
  end

  function automatic bit [7:0] expRead(input bit [2:0] a);
    case (a)
      3'd0: return {mFlag, 3'b000, mSel, mIe, mRun};
      3'd1: return mPre[15:8];
      3'd2: return mPre[7:0];
      3'd3: return mCnt[15:8];
      3'd4: return mFrozen ? mHold : mCnt[7:0];
      default: return 8'h00;
    endcase
  endfunction

  // compare against the model on every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (irq !== (mFlag && mIe)) begin
        fails++;
        $display("FAIL R7: irq=%b expected %b", irq, mFlag && mIe);
      end
      if (rdEn) begin
        checks++;
        if (rdData !== expRead(addr)) begin
          fails++;
          $display("FAIL %s: rdData[addr %0d]=%h expected %h", curTag, addr, rdData, expRead(addr));
        end
      end
    end
  end

  task automatic busWr(input bit [2:0] a, input bit [7:0] d, input string t);
    curTag = t; addr = a; wrData = d; wrEn = 1'b1;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic busRd(input bit [2:0] a, input string t);
    curTag = t; addr = a; rdEn = 1'b1;
    @(posedge clk); #1;
    rdEn = 1'b0;
  endtask

  // read with a fixed expectation worked out from the requirements
  task automatic busRdFixed(input bit [2:0] a, input bit [7:0] mask, input bit [7:0] exp, input string t);
    curTag = t; addr = a; rdEn = 1'b1;
    @(negedge clk);
    checks++;
    if ((rdData & mask) !== exp) begin
      fails++;
      $display("FAIL %s: rdData[addr %0d]&%h=%h expected %h", t, a, mask, rdData & mask, exp);
    end
    @(posedge clk); #1;
    rdEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog: run still active, expected completion");
    finishRun();
  end

  initial begin
    idle(4);
    @(posedge clk); #1;
    rst = 1'b0;
    idle(1);

    // R1: reset state
    busRdFixed(3'd0, 8'hFF, 8'h00, "R1");
    busRdFixed(3'd3, 8'hFF, 8'h00, "R1");
    busRd(3'd4, "R1");
    busRd(3'd1, "R1");

    // R2: start value bytes
    busWr(3'd1, 8'h12, "R2");
    busWr(3'd2, 8'h34, "R2");
    busRdFixed(3'd1, 8'hFF, 8'h12, "R2");
    busRdFixed(3'd2, 8'hFF, 8'h34, "R2");

    // R4: nothing moves while stopped
    idle(10);
    busRdFixed(3'd3, 8'hFF, 8'h00, "R4");

    // R3, R6, R7: short period, interrupt enabled, divide by one
    busWr(3'd1, 8'h00, "R3");
    busWr(3'd2, 8'h05, "R3");
    busWr(3'd0, 8'h03, "R3");
    busRd(3'd4, "R3");
    idle(8);
    busRd(3'd0, "R6");
    // R6: new start value used at next reload
    busWr(3'd2, 8'h09, "R6");
    idle(14);
    busRd(3'd4, "R6");

    // R8: write 1 to flag keeps it, write 0 clears it
    busWr(3'd0, 8'h83, "R8");
    busRd(3'd0, "R8");
    busWr(3'd0, 8'h03, "R8");
    busRd(3'd0, "R8");

    // R7: interrupt enable off masks irq with flag pending
    idle(12);
    busWr(3'd0, 8'h81, "R7");
    idle(3);
    busRd(3'd0, "R7");

    // R3: writing run=1 while running must not reload
    busRd(3'd4, "R3");
    busWr(3'd0, 8'h81, "R3");
    busRd(3'd4, "R3");

    // R4: stop freezes count
    busWr(3'd0, 8'h00, "R4");
    busRd(3'd4, "R4");
    idle(9);
    busRd(3'd4, "R4");

    // R8: clear and expiry in the same cycle
    busWr(3'd2, 8'h04, "R8");
    busWr(3'd0, 8'h03, "R8");
    while (mCnt != 16'd1) begin @(posedge clk); #1; end
    busWr(3'd0, 8'h03, "R8");
    busRdFixed(3'd0, 8'h80, 8'h80, "R8");
    busWr(3'd0, 8'h00, "R8");

    // R5: each rate code
    for (int s = 1; s < 4; s++) begin
      busWr(3'd1, 8'h00, "R5");
      busWr(3'd2, 8'h40, "R5");
      busWr(3'd0, 8'((s << 2) | 1), "R5");
      idle(5 + 3 * s);
      busRd(3'd4, "R5");
      idle(17);
      busRd(3'd4, "R5");
      busRd(3'd0, "R5");
      busWr(3'd0, 8'h00, "R5");
    end

    // R9: coherent two-byte read of a running count crossing a high-byte step
    busWr(3'd1, 8'h03, "R9");
    busWr(3'd2, 8'h02, "R9");
    busWr(3'd0, 8'h01, "R9");
    idle(1);
    busRd(3'd3, "R9");
    idle(3);
    busRd(3'd3, "R9");
    idle(2);
    busRd(3'd4, "R9");
    busRd(3'd4, "R9");
    busRd(3'd3, "R9");
    busRd(3'd4, "R9");
    idle(2);
    busRd(3'd4, "R9");

    idle(2);
    finishRun();
  end

endmodule